// File: doc/BRIEF.md
# Parameter Slew Bank

This block keeps 64 parameter slots for an audio processing datapath. Each slot holds a current value and a target value. Both are 28-bit signed fixed-point numbers with 5 integer bits, the sign among them, and 23 fractional bits. A host writes only the target, the curve and the rate of a slot. The current value never jumps to a new target. Instead, every sample tick starts a sweep, and the sweep moves each slot one step closer to its target.

A sweep visits the slots in ascending order, one slot per clock, and raises a busy flag while it runs. Each slot follows one of two curves:

- **Linear:** the value moves by a fixed power-of-two step.
- **Logarithmic:** the value moves by a power-of-two fraction of the remaining distance.

Both curves land exactly on the target and never pass it. A combinational read port gives the datapath the current value of any slot, along with a flag that shows whether that slot has settled.

Top module: `slew_bank`

## Requirements
- R1: After reset every slot has a current value and a target of 0, every slot reads as settled, and busy_o is low.
- R2: A host write stores a new target, curve and rate for one slot and leaves that slot's current value unchanged. Outside a sweep, no current value ever changes.
- R3: A tick_i pulse seen while idle starts a sweep. busy_o then stays high for exactly 64 cycles and updates slots 0 to 63 in ascending order, one per clock.
- R4: A tick_i pulse that arrives while a sweep is running is ignored. The sweep neither restarts nor lengthens, and each slot moves only one step for that sweep.
- R5: With the linear curve (mode bit 0), each sweep moves the value by a step of 2^min(rate,27) LSB toward the target. When the remaining distance is no larger than that step, the value is set exactly to the target.
- R6: With the logarithmic curve (mode bit 1), each sweep moves the value by floor(|target-current| / 2^rate) toward the target. When that step is zero, the value is set exactly to the target.
- R7: rd_done_o is high exactly when the current value of the addressed slot equals its target.
- R8: A target written while a slot is ramping is accepted. The next sweeps move from the present current value toward the new target.
- R9: When a host write and a sweep update hit the same slot in the same clock, the update uses the newly written target, curve and rate.
- R10: Values are two's complement. A ramp across the full range, from +0x7FFFFFF to -0x8000000, takes the correct direction and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick pulse; starts a sweep when the block is idle |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 6 | Slot that the host writes |
| wr_target_i | input | 28 | New target value (signed, 5.23) |
| wr_mode_i | input | 1 | Curve: 0 for linear, 1 for logarithmic |
| wr_rate_i | input | 5 | Rate exponent: linear step exponent, or logarithmic shift |
| rd_addr_i | input | 6 | Slot that the read port addresses |
| rd_value_o | output | 28 | Current value of the addressed slot |
| rd_done_o | output | 1 | High when the addressed slot has reached its target |
| busy_o | output | 1 | High while a sweep is in progress |

## Verification
A host write to a slot can land in the same clock as the sweep step for that slot. Both act on the same slot state in one edge. The bench provokes this by counting clocks from the start of a sweep and placing the write exactly in the cycle in which the sequencer visits slot 20.

The write changes that slot from a resting state to a logarithmic curve with target 1000 and shift 1. The bench then reads the value after the sweep. A value of 500 shows that the update used the new settings. A value of 0 would show that the update used the stale ones.

// File: rtl/slew_pkg.sv
package slew_pkg;
  typedef enum logic {
    CURVE_LIN = 1'b0,
    CURVE_LOG = 1'b1
  } curve_e;
endpackage

// File: rtl/slew_seq.sv
module slew_seq #(
  parameter int N_SLOTS = 64,
  localparam int IDX_W = $clog2(N_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SLOTS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (busy_o) begin
      if (idx_o == LAST) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end else if (tick_i) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end
  end

  p_start_at_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> idx_o == '0);

  p_ends_on_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(idx_o) == LAST);

  // a tick during a sweep must not restart the walk
  p_tick_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && idx_o != LAST) |=> (busy_o && idx_o == IDX_W'($past(idx_o) + 1'b1)));
endmodule

// File: rtl/slew_step.sv
module slew_step
  import slew_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int RATE_W = 5
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] tgt_i,
  input  curve_e            curve_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [DATA_W-1:0] nxt_o
);
  localparam int EW = DATA_W + 1;
  localparam logic [RATE_W-1:0] MAX_SH = RATE_W'(DATA_W - 1);

  logic [EW-1:0] cur_w, tgt_w, diff, mag, step_lin, step_log, step, nxt_w;
  logic [RATE_W-1:0] sh_lin;
  logic land;
  logic unused_msb;

  always_comb begin
    cur_w    = {cur_i[DATA_W-1], cur_i};
    tgt_w    = {tgt_i[DATA_W-1], tgt_i};
    diff     = tgt_w - cur_w;  // one extra bit: never wraps
    mag      = diff[EW-1] ? (~diff + 1'b1) : diff;
    sh_lin   = (rate_i > MAX_SH) ? MAX_SH : rate_i;
    step_lin = EW'(1) << sh_lin;
    step_log = mag >> rate_i;
    if (curve_i == CURVE_LOG) begin
      step = step_log;
      land = (step_log == '0);
    end else begin
      step = step_lin;
      land = (mag <= step_lin);
    end
    nxt_w = diff[EW-1] ? (cur_w - step) : (cur_w + step);
    nxt_o = land ? tgt_i : nxt_w[DATA_W-1:0];
  end

  assign unused_msb = nxt_w[EW-1];
endmodule

// File: rtl/slew_store.sv
module slew_store
  import slew_pkg::*;
#(
  parameter int N_SLOTS = 64,
  parameter int DATA_W  = 28,
  parameter int RATE_W  = 5,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_target_i,
  input  curve_e            wr_curve_i,
  input  logic [RATE_W-1:0] wr_rate_i,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [DATA_W-1:0] upd_val_i,
  output logic [DATA_W-1:0] sel_cur_o,
  output logic [DATA_W-1:0] sel_tgt_o,
  output curve_e            sel_curve_o,
  output logic [RATE_W-1:0] sel_rate_o,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_cur_o,
  output logic [DATA_W-1:0] rd_tgt_o
);
  logic [DATA_W-1:0] cur_q  [N_SLOTS];
  logic [DATA_W-1:0] tgt_q  [N_SLOTS];
  curve_e            crv_q  [N_SLOTS];
  logic [RATE_W-1:0] rate_q [N_SLOTS];
  logic hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SLOTS; i++) cur_q[i] <= '0;
    end else if (upd_en_i) begin
      cur_q[upd_idx_i] <= upd_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SLOTS; i++) begin
        tgt_q[i]  <= '0;
        crv_q[i]  <= CURVE_LIN;
        rate_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      tgt_q[wr_addr_i]  <= wr_target_i;
      crv_q[wr_addr_i]  <= wr_curve_i;
      rate_q[wr_addr_i] <= wr_rate_i;
    end
  end

  // same-cycle write to the slot being stepped: new settings win
  assign hit         = wr_en_i && (wr_addr_i == upd_idx_i);
  assign sel_cur_o   = cur_q[upd_idx_i];
  assign sel_tgt_o   = hit ? wr_target_i : tgt_q[upd_idx_i];
  assign sel_curve_o = hit ? wr_curve_i  : crv_q[upd_idx_i];
  assign sel_rate_o  = hit ? wr_rate_i   : rate_q[upd_idx_i];

  assign rd_cur_o = cur_q[rd_addr_i];
  assign rd_tgt_o = tgt_q[rd_addr_i];
endmodule

// File: rtl/slew_bank.sv
module slew_bank
  import slew_pkg::*;
#(
  parameter int N_SLOTS = 64,
  parameter int DATA_W  = 28,
  parameter int RATE_W  = 5,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_target_i,
  input  logic              wr_mode_i,
  input  logic [RATE_W-1:0] wr_rate_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_value_o,
  output logic              rd_done_o,
  output logic              busy_o
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] upd_cur, upd_tgt, upd_nxt, rd_tgt;
  curve_e            upd_curve;
  logic [RATE_W-1:0] upd_rate;

  slew_seq #(.N_SLOTS(N_SLOTS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .busy_o (busy_o),
    .idx_o  (idx)
  );

  slew_store #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W), .RATE_W(RATE_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_target_i (wr_target_i),
    .wr_curve_i  (curve_e'(wr_mode_i)),
    .wr_rate_i   (wr_rate_i),
    .upd_en_i    (busy_o),
    .upd_idx_i   (idx),
    .upd_val_i   (upd_nxt),
    .sel_cur_o   (upd_cur),
    .sel_tgt_o   (upd_tgt),
    .sel_curve_o (upd_curve),
    .sel_rate_o  (upd_rate),
    .rd_addr_i   (rd_addr_i),
    .rd_cur_o    (rd_value_o),
    .rd_tgt_o    (rd_tgt)
  );

  slew_step #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_step (
    .cur_i   (upd_cur),
    .tgt_i   (upd_tgt),
    .curve_i (upd_curve),
    .rate_i  (upd_rate),
    .nxt_o   (upd_nxt)
  );

  assign rd_done_o = (rd_value_o == rd_tgt);

  p_no_overshoot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (($signed(upd_tgt) >= $signed(upd_cur))
      ? ($signed(upd_nxt) >= $signed(upd_cur) && $signed(upd_nxt) <= $signed(upd_tgt))
      : ($signed(upd_nxt) <= $signed(upd_cur) && $signed(upd_nxt) >= $signed(upd_tgt))));

  p_progress_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && upd_cur != upd_tgt) |-> upd_nxt != upd_cur);

  p_no_jump_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && $stable(rd_addr_i)) |-> $stable(rd_value_o));
endmodule

// File: tb/slew_bank_test.sv
module slew_bank_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0]  addr;
    logic [27:0] tgt;
    logic        mode;
    logic [4:0]  rate;
    logic [7:0]  ticks;
    logic [27:0] exp_v;
  } vec_t;

  // each entry: fresh slot, write, apply ticks, expect current value
  localparam vec_t VEC [9] = '{
    '{6'd1, 28'd100,        1'b0, 5'd2,  8'd1,  28'd4},         // R5
    '{6'd2, 28'd100,        1'b0, 5'd2,  8'd30, 28'd100},       // R5 lands
    '{6'd3, 28'hFFFFFCE,    1'b0, 5'd3,  8'd2,  28'hFFFFFF0},   // R5 negative
    '{6'd4, 28'd1024,       1'b1, 5'd1,  8'd1,  28'd512},       // R6
    '{6'd5, 28'd1024,       1'b1, 5'd1,  8'd2,  28'd768},       // R6
    '{6'd6, 28'hFFFFC18,    1'b1, 5'd2,  8'd1,  28'hFFFFF06},   // R6 negative
    '{6'd7, 28'd3,          1'b1, 5'd2,  8'd1,  28'd3},         // R6 snap
    '{6'd8, 28'h7FFFFFF,    1'b0, 5'd31, 8'd1,  28'h7FFFFFF},   // R5 clamp
    '{6'd9, 28'd1000,       1'b1, 5'd0,  8'd1,  28'd1000}       // R6 shift 0
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [5:0] wr_addr_i = '0;
  logic [27:0] wr_target_i = '0;
  logic wr_mode_i = 1'b0;
  logic [4:0] wr_rate_i = '0;
  logic [5:0] rd_addr_i = '0;
  logic [27:0] rd_value_o;
  logic rd_done_o;
  logic busy_o;

  int n_run = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  slew_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_target_i(wr_target_i),
    .wr_mode_i(wr_mode_i), .wr_rate_i(wr_rate_i),
    .rd_addr_i(rd_addr_i), .rd_value_o(rd_value_o),
    .rd_done_o(rd_done_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic host_wr(input logic [5:0] a, input logic [27:0] t,
                         input logic m, input logic [4:0] r);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_target_i = t; wr_mode_i = m; wr_rate_i = r;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [27:0] v, output logic d);
    rd_addr_i = a;
    #1;
    v = rd_value_o;
    d = rd_done_o;
  endtask

  task automatic do_tick(output int cyc);
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    cyc = 0;
    while (busy_o) begin
      cyc++;
      @(negedge clk_i);
    end
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [27:0] v;
    logic d;
    int cyc;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 busy", {27'd0, busy_o}, 28'd0);
    rd(6'd0, v, d);  chk("R1 value slot0", v, 28'd0); chk("R1 done slot0", {27'd0, d}, 28'd1);
    rd(6'd63, v, d); chk("R1 value slot63", v, 28'd0); chk("R1 done slot63", {27'd0, d}, 28'd1);

    // R2 write does not move current
    host_wr(6'd10, 28'd500, 1'b0, 5'd0);
    repeat (3) @(negedge clk_i);
    rd(6'd10, v, d);
    chk("R2 no jump", v, 28'd0);
    chk("R7 not done", {27'd0, d}, 28'd0);

    // R3 sweep length
    do_tick(cyc);
    chk("R3 busy cycles", 28'(cyc), 28'd64);
    rd(6'd10, v, d);
    chk("R3 one step", v, 28'd1);

    // vector table: R5, R6, R7
    foreach (VEC[i]) begin
      host_wr(VEC[i].addr, VEC[i].tgt, VEC[i].mode, VEC[i].rate);
      for (int t = 0; t < int'(VEC[i].ticks); t++) do_tick(cyc);
      rd(VEC[i].addr, v, d);
      chk(VEC[i].mode ? "R6 value" : "R5 value", v, VEC[i].exp_v);
      chk("R7 done flag", {27'd0, d}, {27'd0, VEC[i].exp_v == VEC[i].tgt});
    end

    // R4 tick during sweep ignored
    host_wr(6'd11, 28'd100, 1'b0, 5'd0);
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    cyc = 0;
    while (busy_o) begin
      cyc++;
      tick_i = (cyc == 10);
      @(negedge clk_i);
    end
    tick_i = 1'b0;
    chk("R4 busy cycles", 28'(cyc), 28'd64);
    repeat (2) @(negedge clk_i);
    chk("R4 no restart", {27'd0, busy_o}, 28'd0);
    rd(6'd11, v, d);
    chk("R4 single step", v, 28'd1);

    // R8 retarget mid-ramp
    host_wr(6'd12, 28'd100, 1'b0, 5'd2);
    for (int t = 0; t < 3; t++) do_tick(cyc);
    rd(6'd12, v, d);
    chk("R8 before retarget", v, 28'd12);
    host_wr(6'd12, 28'hFFFFF9C, 1'b0, 5'd2);
    do_tick(cyc);
    rd(6'd12, v, d);
    chk("R8 after retarget", v, 28'd8);

    // R9 write and update of slot 20 in the same edge
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    repeat (20) @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 6'd20; wr_target_i = 28'd1000; wr_mode_i = 1'b1; wr_rate_i = 5'd1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    rd(6'd20, v, d);
    chk("R9 collision uses new settings", v, 28'd500);

    // R10 full-range ramp
    host_wr(6'd30, 28'h7FFFFFF, 1'b0, 5'd31);
    do_tick(cyc);
    rd(6'd30, v, d);
    chk("R10 reach max", v, 28'h7FFFFFF);
    host_wr(6'd30, 28'h8000000, 1'b0, 5'd31);
    do_tick(cyc);
    rd(6'd30, v, d);
    chk("R10 midway down", v, 28'hFFFFFFF);
    do_tick(cyc);
    rd(6'd30, v, d);
    chk("R10 reach min", v, 28'h8000000);
    chk("R10 done", {27'd0, d}, 28'd1);

    finish_run();
  end
endmodule